// File: doc/BRIEF.md
# Descriptor gather copy sequencer

This block takes 128-bit copy descriptors, one per handshake, and turns each into a series of byte-granular memory read requests. Each request covers one to four bytes and never crosses a 4-byte boundary. The returned words go out, in order, on a single destination write stream. Descriptors can be chained with a gather flag. A chain of gather descriptors becomes one destination transfer, closed by the first descriptor whose gather flag is clear. The last beat of that transfer carries a last flag, and the metadata and hash-enable latched for the group are shown next to it.

The 40-bit buffer pointer is split three ways. The low bits become the request address. The next bits become request user bits. The top bit selects one of two virtual channels. The swap and hash-enable attributes and the metadata come only from the opening descriptor of a group. Byte swapping can be applied on the read side, the write side, or both; when both are on, the two swaps cancel.

The controller has four states:
- `S_IDLE` accepts a descriptor.
- `S_BARRIER` waits for outstanding reads to drain.
- `S_ISSUE` issues read requests.
- `S_CLOSE` drains the group and, if needed, emits an empty closing beat.

Transitions:
- `S_IDLE`→`S_ISSUE`: a non-empty descriptor without barrier.
- `S_IDLE`→`S_BARRIER`: a non-empty descriptor with barrier.
- `S_IDLE`→`S_CLOSE`: a zero-length descriptor with gather clear.
- `S_IDLE`→`S_IDLE`: a zero-length descriptor with gather set.
- `S_BARRIER`→`S_ISSUE`: the outstanding count reaches zero.
- `S_ISSUE`→`S_IDLE`: the final request of a gather-set descriptor is sent.
- `S_ISSUE`→`S_CLOSE`: the final request of a group-ending descriptor is sent.
- `S_CLOSE`→`S_IDLE`: reads have drained and any empty beat has been accepted.

Top module: `gather_copy_seq`

## Requirements
- R1: Descriptor fields are decoded from fixed positions. Word k is `desc_data[32k+31:32k]`. The pointer is {word1[7:0], word0}. Word1 holds hash enable in bit 8, read swap in bit 9, write swap in bit 10, gather in bit 11, barrier in bit 13 and the byte length in bits [31:16]. Word2[15:0] holds the metadata. The request address is pointer[36:0], the request user bits are pointer[38:37] and the channel select is pointer[39] (0 = channel 0, 1 = channel 1).
- R2: A descriptor of length L produces requests at consecutive byte addresses. Each request has a byte count of min(4 − addr[1:0], bytes left), and the counts sum to L. A pending request holds its address and count until it is accepted. Addresses wrap modulo 2^37.
- R3: With read swap on, each returned word has bytes 0↔3 and 1↔2 exchanged before it is written.
- R4: With write swap on, the same exchange is applied to each written word. With both swaps on, the data passes through unchanged.
- R5: The swaps, hash enable and metadata of a gather group are taken from its first descriptor. Values of these fields in later descriptors of the group have no effect on the written data, `wr_meta` or `wr_hash_en`.
- R6: The last written beat of a group has `wr_last`=1 and no other beat does. On that beat `wr_meta` and `wr_hash_en` show the group's latched values.
- R7: A zero-length descriptor issues no read. If it ends a group, then once all reads have drained the block emits one beat with `wr_bytes`=0 and `wr_last`=1.
- R8: A descriptor with the barrier flag issues its first read only when no read is outstanding.
- R9: At most MAX_OUT reads are outstanding. After a group-ending descriptor, the next descriptor is accepted only when no read is outstanding.
- R10: After reset, `desc_ready`=1, `rd_req_valid`=0 and `wr_valid`=0.
- R11: Reserved bits, the ring id and the loop count have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_data | input | 128 | Four descriptor words, word 0 in the low bits |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W (37) | Byte address of the request |
| rd_req_bytes | output | 3 | Byte count, 1 to 4 |
| rd_req_user | output | USER_W (2) | Pointer user bits |
| rd_req_vc | output | 1 | Virtual channel select |
| rd_rsp_valid | input | 1 | Read data returned, in request order, requested bytes in low lanes |
| rd_rsp_ready | output | 1 | Read data taken |
| rd_rsp_data | input | 32 | Read data word |
| wr_valid | output | 1 | Destination beat valid |
| wr_ready | input | 1 | Destination beat accepted |
| wr_data | output | 32 | Destination data word |
| wr_bytes | output | 3 | Valid bytes in the beat, 0 to 4 |
| wr_last | output | 1 | Final beat of the group |
| wr_meta | output | 16 | Group metadata |
| wr_hash_en | output | 1 | Group hash enable |

## Verification
A wrong tag entry shows on the very next destination beat as a byte count or last flag that does not match the requested chunk. A group attribute latched from the wrong descriptor shows as swapped data within one beat of the first affected response, or as wrong metadata on the closing beat. A miscounted outstanding total shows as a read issued during a barrier or a descriptor taken before drain. Because that check is made at the request or descriptor handshake itself, the error is seen at the handshake where it occurs.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
    localparam int DESC_W = 128;
    localparam int PTR_W  = 40;
    localparam int LEN_W  = 16;
    localparam int META_W = 16;

    typedef enum logic [1:0] {S_IDLE, S_BARRIER, S_ISSUE, S_CLOSE} state_t;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic              hash_en;
        logic              rd_swap;
        logic              wr_swap;
        logic              gather;
        logic              barrier;
        logic [LEN_W-1:0]  len;
        logic [META_W-1:0] meta;
    } desc_t;

    typedef struct packed {
        logic       last;
        logic [2:0] bytes;
    } tag_t;

    function automatic desc_t unpack_desc(input logic [DESC_W-1:0] d);
        desc_t r;
        r.ptr     = {d[39:32], d[31:0]};
        r.hash_en = d[40];
        r.rd_swap = d[41];
        r.wr_swap = d[42];
        r.gather  = d[43];
        r.barrier = d[45];
        r.len     = d[63:48];
        r.meta    = d[79:64];
        return r;
    endfunction

    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/gcs_tag_fifo.sv
module gcs_tag_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_idx] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_idx <= (wr_idx == IDX_W'(DEPTH - 1)) ? '0 : wr_idx + 1'b1;
            if (do_pop)  rd_idx <= (rd_idx == IDX_W'(DEPTH - 1)) ? '0 : rd_idx + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/gcs_chunker.sv
module gcs_chunker #(
    parameter int LEN_W = 16
) (
    input  logic [1:0]       addr_lo,
    input  logic [LEN_W-1:0] remain,
    output logic [2:0]       chunk
);
    logic [2:0] room;

    always_comb begin
        room  = 3'd4 - {1'b0, addr_lo};
        chunk = (remain < LEN_W'(room)) ? remain[2:0] : room;
    end
endmodule

// File: rtl/gather_copy_seq.sv
module gather_copy_seq
    import gcs_pkg::*;
#(
    parameter int ADDR_W  = 37,
    parameter int MAX_OUT = 4,
    parameter int USER_W  = PTR_W - 1 - ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [DESC_W-1:0] desc_data,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [2:0]        rd_req_bytes,
    output logic [USER_W-1:0] rd_req_user,
    output logic              rd_req_vc,
    input  logic              rd_rsp_valid,
    output logic              rd_rsp_ready,
    input  logic [31:0]       rd_rsp_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [31:0]       wr_data,
    output logic [2:0]        wr_bytes,
    output logic              wr_last,
    output logic [META_W-1:0] wr_meta,
    output logic              wr_hash_en
);
    localparam int CNT_W = $clog2(MAX_OUT + 1);
    localparam int TAG_W = $bits(tag_t);

    state_t state, nxt;
    desc_t  dd;

    logic [ADDR_W-1:0] cur_addr;
    logic [USER_W-1:0] cur_user;
    logic              cur_vc;
    logic [LEN_W-1:0]  remain;
    logic              is_final, zero_close, grp_open;
    logic              g_rd_swap, g_wr_swap, g_hash;
    logic [META_W-1:0] g_meta;

    logic [2:0]        chunk;
    logic              req_fire, desc_fire, rsp_fire, empty_beat, last_chunk;
    tag_t              tag_in, tag_out;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_empty, fifo_full;
    logic [31:0]       rsp_sw;

    // Reserved fields, ring id and loop count are sunk here on purpose.
    logic [DESC_W-1:0] unused_desc;
    assign unused_desc = desc_data;

    assign dd = unpack_desc(desc_data);

    gcs_chunker #(.LEN_W(LEN_W)) u_chunk (
        .addr_lo (cur_addr[1:0]),
        .remain  (remain),
        .chunk   (chunk)
    );

    assign tag_in = '{last: is_final && last_chunk, bytes: chunk};

    gcs_tag_fifo #(.DEPTH(MAX_OUT), .W(TAG_W), .CNT_W(CNT_W)) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (req_fire),
        .din   (tag_in),
        .pop   (rsp_fire),
        .dout  (tag_out),
        .count (fifo_cnt),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assign last_chunk = (remain == LEN_W'(chunk));
    assign desc_fire  = desc_valid && desc_ready;
    assign req_fire   = rd_req_valid && rd_req_ready;
    assign rsp_fire   = rd_rsp_valid && rd_rsp_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (desc_valid) begin
                if (dd.len == '0)    nxt = dd.gather ? S_IDLE : S_CLOSE;
                else if (dd.barrier) nxt = S_BARRIER;
                else                 nxt = S_ISSUE;
            end
            S_BARRIER: if (fifo_cnt == '0) nxt = S_ISSUE;
            S_ISSUE:   if (req_fire && last_chunk) nxt = is_final ? S_CLOSE : S_IDLE;
            S_CLOSE:   if (fifo_cnt == '0 && (!zero_close || wr_ready)) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        desc_ready   = (state == S_IDLE);
        rd_req_valid = (state == S_ISSUE) && !fifo_full;
        rd_req_addr  = cur_addr;
        rd_req_bytes = chunk;
        rd_req_user  = cur_user;
        rd_req_vc    = cur_vc;
        empty_beat   = (state == S_CLOSE) && zero_close && (fifo_cnt == '0);
        rd_rsp_ready = wr_ready && !fifo_empty;
        rsp_sw       = g_rd_swap ? swap_bytes(rd_rsp_data) : rd_rsp_data;
        wr_valid     = empty_beat || (rd_rsp_valid && !fifo_empty);
        wr_data      = empty_beat ? '0 : (g_wr_swap ? swap_bytes(rsp_sw) : rsp_sw);
        wr_bytes     = empty_beat ? 3'd0 : tag_out.bytes;
        wr_last      = empty_beat || (!fifo_empty && tag_out.last);
        wr_meta      = g_meta;
        wr_hash_en   = g_hash;
    end

    // Descriptor and group registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            cur_user   <= '0;
            cur_vc     <= 1'b0;
            remain     <= '0;
            is_final   <= 1'b0;
            zero_close <= 1'b0;
            grp_open   <= 1'b0;
            g_rd_swap  <= 1'b0;
            g_wr_swap  <= 1'b0;
            g_hash     <= 1'b0;
            g_meta     <= '0;
        end else if (desc_fire) begin
            cur_addr   <= dd.ptr[ADDR_W-1:0];
            cur_user   <= dd.ptr[PTR_W-2:ADDR_W];
            cur_vc     <= dd.ptr[PTR_W-1];
            remain     <= dd.len;
            is_final   <= !dd.gather;
            zero_close <= !dd.gather && (dd.len == '0);
            grp_open   <= dd.gather;
            if (!grp_open) begin
                g_rd_swap <= dd.rd_swap;
                g_wr_swap <= dd.wr_swap;
                g_hash    <= dd.hash_en;
                g_meta    <= dd.meta;
            end
        end else if (req_fire) begin
            cur_addr <= cur_addr + ADDR_W'(chunk);
            remain   <= remain - LEN_W'(chunk);
        end
    end
endmodule

// File: rtl/gcs_chk.sv
module gcs_chk #(
    parameter int ADDR_W  = 37,
    parameter int MAX_OUT = 4,
    parameter int CNT_W   = $clog2(MAX_OUT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic [2:0]        rd_req_bytes,
    input logic              wr_valid,
    input logic [2:0]        wr_bytes,
    input logic              wr_last,
    input logic [CNT_W-1:0]  fifo_cnt
);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=>
            rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_bytes));

    // R2
    chunk_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_bytes != 3'd0) &&
            ({1'b0, rd_req_addr[1:0]} + rd_req_bytes <= 3'd4));

    // R7
    empty_beat_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_bytes == 3'd0 |-> wr_last);

    // R7
    empty_beat_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_bytes == 3'd0 |-> fifo_cnt == '0);
endmodule

bind gather_copy_seq gcs_chk #(.ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_req_bytes (rd_req_bytes),
    .wr_valid     (wr_valid),
    .wr_bytes     (wr_bytes),
    .wr_last      (wr_last),
    .fifo_cnt     (fifo_cnt)
);

// File: tb/tb_gather_copy_seq.sv
module tb_gather_copy_seq;
    localparam int MAXO = 4;

    logic clk = 0, rst_n = 0;
    logic desc_valid = 0, desc_ready;
    logic [127:0] desc_data = '0;
    logic rd_req_valid, rd_req_ready = 0;
    logic [36:0] rd_req_addr;
    logic [2:0] rd_req_bytes;
    logic [1:0] rd_req_user;
    logic rd_req_vc;
    logic rd_rsp_valid = 0, rd_rsp_ready;
    logic [31:0] rd_rsp_data = '0;
    logic wr_valid, wr_ready = 0;
    logic [31:0] wr_data;
    logic [2:0] wr_bytes;
    logic wr_last;
    logic [15:0] wr_meta;
    logic wr_hash_en;

    always #5 clk = ~clk;

    gather_copy_seq #(.ADDR_W(37), .MAX_OUT(MAXO)) dut (.*);

    int nchk = 0, nerr = 0, cyc = 0, lat = 3, nseed = 1;
    bit last_final = 0;
    bit m_open = 0, m_src = 0, m_dst = 0, m_hash = 0;
    logic [15:0] m_meta = '0;

    logic [127:0] dq[$];
    logic [36:0] er_addr[$];
    logic [2:0]  er_bytes[$];
    logic [1:0]  er_user[$];
    bit          er_vc[$], er_bar[$];
    logic [31:0] eb_data[$];
    logic [2:0]  eb_bytes[$];
    bit          eb_last[$], eb_hash[$];
    logic [15:0] eb_meta[$];
    logic [31:0] pd_data[$];
    int          pd_time[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] mem_word(input logic [36:0] a, input int n);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++)
            if (i < n) w[8*i +: 8] = 8'(a + 37'(i)) ^ 8'h5A;
        return w;
    endfunction

    // Builds one descriptor with noise in ignored fields (R11) and its expected traffic.
    task automatic add_desc(input logic [39:0] ptr, input int len, input bit hash, input bit src,
                            input bit dst, input bit gath, input bit barr, input logic [15:0] meta);
        logic [31:0] w1, w2, w3, nz, d;
        logic [36:0] a;
        int rem, n;
        bit first;
        nseed++;
        nz = (32'(nseed) * 32'h9E3779B9) ^ 32'h5BD1E995;
        w1 = {len[15:0], nz[1:0], barr, nz[2], gath, dst, src, hash, ptr[39:32]};
        w2 = {nz[31:16], meta};
        w3 = nz ^ 32'h1234_5678;
        dq.push_back({w3, w2, w1, ptr[31:0]});
        if (!m_open) begin
            m_src = src; m_dst = dst; m_hash = hash; m_meta = meta;
        end
        a = ptr[36:0]; rem = len; first = 1;
        while (rem > 0) begin
            n = 4 - int'(a[1:0]);
            if (rem < n) n = rem;
            er_addr.push_back(a); er_bytes.push_back(n[2:0]);
            er_user.push_back(ptr[38:37]); er_vc.push_back(ptr[39]);
            er_bar.push_back(barr && first);
            d = mem_word(a, n);
            if (m_src) d = sw(d);
            if (m_dst) d = sw(d);
            eb_data.push_back(d); eb_bytes.push_back(n[2:0]);
            eb_last.push_back(!gath && rem == n);
            eb_meta.push_back(m_meta); eb_hash.push_back(m_hash);
            a = a + 37'(n); rem -= n; first = 0;
        end
        if (len == 0 && !gath) begin
            eb_data.push_back('0); eb_bytes.push_back(3'd0); eb_last.push_back(1);
            eb_meta.push_back(m_meta); eb_hash.push_back(m_hash);
        end
        m_open = gath;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            desc_valid   = dq.size() > 0;
            desc_data    = desc_valid ? dq[0] : '0;
            rd_req_ready = (cyc % 5) != 2;
            wr_ready     = (cyc % 7) != 4;
            rd_rsp_valid = pd_data.size() > 0 && cyc >= pd_time[0];
            rd_rsp_data  = rd_rsp_valid ? pd_data[0] : '0;
            #1;
            if (desc_valid && desc_ready) begin
                if (last_final)
                    chk(pd_data.size() == 0, "R9 next group before drain", 64'(pd_data.size()), 0);
                last_final = !desc_data[43];
                void'(dq.pop_front());
            end
            if (rd_req_valid && rd_req_ready) begin
                chk(pd_data.size() < MAXO, "R9 outstanding limit", 64'(pd_data.size()), MAXO);
                if (er_addr.size() == 0) begin
                    chk(0, "R7 unexpected read", 64'(rd_req_addr), 0);
                end else begin
                    chk(rd_req_addr == er_addr[0], "R1 R2 R11 address", 64'(rd_req_addr), 64'(er_addr[0]));
                    chk(rd_req_bytes == er_bytes[0], "R2 byte count", 64'(rd_req_bytes), 64'(er_bytes[0]));
                    chk(rd_req_user == er_user[0] && rd_req_vc == er_vc[0], "R1 user/vc",
                        64'({rd_req_vc, rd_req_user}), 64'({er_vc[0], er_user[0]}));
                    if (er_bar[0])
                        chk(pd_data.size() == 0, "R8 barrier read with reads outstanding", 64'(pd_data.size()), 0);
                    void'(er_addr.pop_front()); void'(er_bytes.pop_front());
                    void'(er_user.pop_front()); void'(er_vc.pop_front()); void'(er_bar.pop_front());
                end
                pd_data.push_back(mem_word(rd_req_addr, int'(rd_req_bytes)));
                pd_time.push_back(cyc + lat);
            end
            if (rd_rsp_valid && rd_rsp_ready) begin
                void'(pd_data.pop_front()); void'(pd_time.pop_front());
            end
            if (wr_valid && wr_ready) begin
                if (eb_bytes.size() == 0) begin
                    chk(0, "R6 unexpected write beat", 64'(wr_data), 0);
                end else begin
                    chk(wr_bytes == eb_bytes[0], "R2 R7 beat bytes", 64'(wr_bytes), 64'(eb_bytes[0]));
                    chk(wr_last == eb_last[0], "R6 last flag", 64'(wr_last), 64'(eb_last[0]));
                    if (eb_bytes[0] != 0)
                        chk(wr_data == eb_data[0], "R3 R4 R5 data", 64'(wr_data), 64'(eb_data[0]));
                    if (eb_last[0])
                        chk(wr_meta == eb_meta[0] && wr_hash_en == eb_hash[0], "R5 R6 meta/hash",
                            64'({wr_hash_en, wr_meta}), 64'({eb_hash[0], eb_meta[0]}));
                    void'(eb_data.pop_front()); void'(eb_bytes.pop_front()); void'(eb_last.pop_front());
                    void'(eb_meta.pop_front()); void'(eb_hash.pop_front());
                end
            end
        end
    end

    task automatic wait_idle();
        while (dq.size() != 0 || er_addr.size() != 0 || eb_bytes.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=hang expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk); #2;
        // R10 reset state
        chk(desc_ready == 1'b1, "R10 desc_ready after reset", 64'(desc_ready), 1);
        chk(rd_req_valid == 1'b0, "R10 rd_req_valid after reset", 64'(rd_req_valid), 0);
        chk(wr_valid == 1'b0, "R10 wr_valid after reset", 64'(wr_valid), 0);

        // Sweep: offset x length x swap combination, single-descriptor groups (R2 R3 R4 R7)
        for (int off = 0; off < 4; off++)
            for (int len = 0; len < 10; len++)
                for (int s = 0; s < 4; s++)
                    add_desc(40'h00_0000_1000 + 40'(off) + 40'(len * 64), len, bit'(s ^ len),
                             bit'(s), bit'(s >> 1), 0, 0, 16'(off * 256 + len * 16 + s));
        wait_idle();

        // Gather chains: later attribute values must have no effect (R5)
        add_desc(40'h00_0000_2001, 5, 1, 1, 0, 1, 0, 16'hBEEF);
        add_desc(40'h00_0000_3002, 3, 0, 0, 1, 1, 0, 16'h1111);
        add_desc(40'h00_0000_4000, 0, 0, 1, 1, 1, 0, 16'h2222);
        add_desc(40'h00_0000_5003, 6, 0, 0, 0, 0, 0, 16'h3333);
        add_desc(40'h00_0000_6000, 4, 0, 0, 1, 1, 0, 16'h0A0A);
        add_desc(40'h00_0000_7001, 0, 1, 1, 0, 0, 0, 16'h5555);
        add_desc(40'h00_0000_8000, 0, 1, 0, 0, 0, 0, 16'h7777);
        wait_idle();

        // Barrier with long read latency (R8)
        lat = 10;
        add_desc(40'h00_0000_9000, 12, 0, 0, 0, 1, 0, 16'h0B0B);
        add_desc(40'h00_0000_A001, 7, 1, 0, 1, 1, 1, 16'h0C0C);
        add_desc(40'h00_0000_B002, 5, 0, 1, 0, 0, 1, 16'h0D0D);
        add_desc(40'h00_0000_C000, 9, 1, 1, 1, 0, 1, 16'h0E0E);
        wait_idle();

        // Channel select, user bits and address wrap (R1)
        lat = 2;
        add_desc(40'hFF_FFFF_FFFE, 6, 1, 0, 1, 0, 0, 16'hF00D);
        add_desc(40'h80_0000_0010, 3, 0, 0, 0, 0, 0, 16'h0101);
        add_desc(40'h60_0000_0021, 4, 0, 1, 0, 0, 0, 16'h0202);
        add_desc(40'h20_1234_5677, 2, 1, 1, 1, 1, 0, 16'h0303);
        add_desc(40'hC0_0000_0100, 8, 0, 0, 0, 0, 1, 16'h0404);
        wait_idle();

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule